// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block sits behind a user-defined JTAG instruction. It turns one Shift-DR scan into one framed SPI transaction to a serial configuration flash. JTAG and SPI both move one bit per clock, so the bridge mostly passes signals through. TDI drives MOSI, TCK drives SCLK, and MISO comes back on TDO. Its own work is to find where the transaction begins in the scan stream and to hold chip select low for exactly the requested number of clocks.

Other TAPs in bypass may sit upstream of the bridge, so a scan can begin with any number of zero bits. The bridge skips them. The first one bit it sees is a start marker and is not sent to the flash. The next 32 bits give the burst length in SPI clocks, most significant bit first. The bridge then runs the counted burst. After the burst, further shift cycles are idle on the flash side. They only carry the returned data through downstream bypass registers to the host. The bridge's own data register is one bit long, so the host sees a read-back delay equal to the number of enabled TAPs.

Top module: `jtag_spi_bridge`

## Requirements
- R1: CS_N is high whenever the user instruction is not selected or the TAP is not in Shift-DR. No SCLK pulse occurs in that case.
- R2: While hunting, zero bits on TDI are skipped. The first one bit is a marker that starts the header. Neither the skipped zeros nor the marker ever reach the flash.
- R3: The 32 bits after the marker form the burst length L, MSB first. CS_N is low for exactly L TCK rising edges, and SCLK shows exactly L rising edges.
- R4: During the burst, the flash receives on MOSI the TDI bits that follow the length field, in their shift order. MOSI is held low while CS_N is high.
- R5: A length of zero skips the burst. CS_N stays high and no SCLK pulse is produced for that scan.
- R6: After the burst, any number of further shift cycles keep CS_N high and SCLK low.
- R7: The 1-bit data register captures on each TCK rising edge. During the burst it captures MISO; otherwise it captures TDI. It presents the captured bit on TDO from the following falling edge, so each bit reaches the host one TCK after the bridge sees it.
- R8: Leaving Shift-DR, or deselecting the instruction, returns the parser to marker hunting. A burst cut short this way ends at once, and the next scan frames cleanly.
- R9: SCLK follows TCK only while CS_N is low and is low otherwise, which gives SPI mode 0 timing. MISO is sampled on the TCK rising edge.
- R10: While TRST_N is low, CS_N is high, TDO is low and SCLK is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data from the scan chain |
| user_sel | input | 1 | High while the bridge's user instruction is selected |
| shift_dr | input | 1 | High while the TAP is in Shift-DR |
| tdo | output | 1 | Serial data toward the scan chain, updated on falling TCK |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |
| cs_n | output | 1 | SPI chip select, active low |

## Verification
A wrong parser state shows first on CS_N. If the marker or the length count is off by one bit, chip select drops or rises one TCK early or late. This appears at the first burst edge. A stuck counter holds CS_N low into the trailing cycles. A wrong choice of data-register source corrupts the bit the host reads back one TCK plus the downstream bypass depth later. The test chain therefore places three bypass stages upstream and two downstream. It compares CS_N and the returned TDO bit on every TCK against a behavioural model, and then compares the bits the flash received and its clock count after each scan.

// File: rtl/jtag_spi_bridge.sv
`timescale 1ns/1ps
module jtag_spi_bridge #(
  parameter int LEN_W = 32
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic user_sel,
  input  logic shift_dr,
  output logic tdo,
  output logic sclk,
  output logic mosi,
  input  logic miso,
  output logic cs_n
);
  localparam int CNT_W = $clog2(LEN_W);

  typedef enum logic [1:0] {HUNT, HDR, BURST, TRAIL} phase_t;

  phase_t             phase;
  logic [CNT_W-1:0]   hdr_cnt;
  logic [LEN_W-1:0]   len_sr;
  logic [LEN_W-1:0]   remain;
  logic               dr_bit;
  logic               cs_q;
  logic               active;
  logic [LEN_W-1:0]   len_next;
  logic               hdr_last;

  assign active   = user_sel & shift_dr;
  assign len_next = {len_sr[LEN_W-2:0], tdi};
  assign hdr_last = (hdr_cnt == CNT_W'(LEN_W-1));

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      phase   <= HUNT;
      hdr_cnt <= '0;
      len_sr  <= '0;
      remain  <= '0;
    end else if (!active) begin
      phase   <= HUNT;
      hdr_cnt <= '0;
    end else begin
      case (phase)
        HUNT: if (tdi) begin
          phase   <= HDR;
          hdr_cnt <= '0;
        end
        HDR: begin
          len_sr  <= len_next;
          hdr_cnt <= hdr_cnt + 1'b1;
          if (hdr_last) begin
            remain <= len_next;
            phase  <= (len_next == '0) ? TRAIL : BURST;
          end
        end
        BURST: begin
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) phase <= TRAIL;
        end
        TRAIL: phase <= TRAIL;
        default: phase <= HUNT;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      dr_bit <= 1'b0;
    else if (!active) dr_bit <= 1'b0;
    else              dr_bit <= (phase == BURST) ? miso : tdi;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo  <= 1'b0;
      cs_q <= 1'b1;
    end else begin
      tdo  <= dr_bit;
      cs_q <= !(active && phase == BURST);
    end
  end

  assign cs_n = cs_q | ~active;
  assign sclk = tck & ~cs_n;
  assign mosi = tdi & ~cs_n;

  p_hunt_zero_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (active && phase == HUNT && !tdi) |=> (phase == HUNT));
  p_len_zero_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (active && phase == HDR && hdr_last && len_next == '0) |=> (phase == TRAIL));
  p_burst_end_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (active && phase == BURST && remain == LEN_W'(1)) |=> (phase == TRAIL));
  p_cs_burst_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (active && phase == BURST) |-> !cs_n);
  p_trail_quiet_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (phase == TRAIL) |-> cs_n);
  p_exit_hunt_r8: assert property (@(posedge tck) disable iff (!trst_n)
    !active |=> (phase == HUNT));
  p_dr_bypass_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (active && phase != BURST) |=> (dr_bit == $past(tdi)));
  p_dr_miso_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (active && phase == BURST) |=> (dr_bit == $past(miso)));
endmodule

// File: tb/tb_jtag_spi_bridge.sv
`timescale 1ns/1ps
module tb_jtag_spi_bridge;
  localparam int NUP  = 3;
  localparam int NDN  = 2;
  localparam int MAXB = 512;

  logic tck = 1'b0, trst_n = 1'b0, host_tdi = 1'b0, sel = 1'b0, shift = 1'b0;
  logic b_tdi, d_tdo, sclk, mosi, cs_n, host_tdo;
  logic miso = 1'b0;
  logic [NUP-1:0] uc = '0, uo = '0;
  logic [NDN-1:0] dc = '0, dq = '0;

  always #2 tck = ~tck;

  always @(posedge tck) begin
    uc <= shift ? {uo[NUP-2:0], host_tdi} : '0;
    dc <= shift ? {dq[NDN-2:0], d_tdo} : '0;
  end
  always @(negedge tck) begin
    uo <= uc;
    dq <= dc;
  end
  assign b_tdi    = uo[NUP-1];
  assign host_tdo = dq[NDN-1];

  jtag_spi_bridge dut (
    .tck(tck), .trst_n(trst_n), .tdi(b_tdi), .user_sel(sel), .shift_dr(shift),
    .tdo(d_tdo), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int   nclk = 0, nglitch = 0;
  logic rx [$];
  logic fl_last = 1'b0;
  always @(posedge sclk) begin
    if (!cs_n) begin
      nclk++;
      rx.push_back(mosi);
      fl_last = mosi;
    end else nglitch++;
  end
  always @(negedge sclk) miso <= fl_last;
  always @(cs_n) begin
    miso    <= 1'b0;
    fl_last = 1'b0;
  end

  int nchecks = 0, nfail = 0;
  bit done = 0;
  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  logic hbits [0:MAXB-1];
  int   nh;
  logic dr_hist [0:MAXB-1];

  task automatic build(input int zeros, input int len, input logic [63:0] data);
    nh = 0;
    for (int i = 0; i < zeros; i++) begin hbits[nh] = 1'b0; nh++; end
    hbits[nh] = 1'b1; nh++;
    for (int i = 31; i >= 0; i--) begin hbits[nh] = len[i]; nh++; end
    for (int i = len - 1; i >= 0; i--) begin hbits[nh] = data[i]; nh++; end
    for (int i = 0; i < NUP + NDN + 3; i++) begin hbits[nh] = 1'b0; nh++; end
  endtask

  task automatic run_scan(input int stop_at);
    int ms, mc, mrem;
    logic [31:0] ml;
    logic b, xfer, drv, prev;
    ms = 0; mc = 0; mrem = 0; ml = '0; prev = 1'b0;
    nclk = 0; nglitch = 0; rx.delete();
    for (int k = 0; k < nh && k < stop_at; k++) begin
      @(negedge tck);
      host_tdi = hbits[k]; sel = 1'b1; shift = 1'b1;
      @(posedge tck);
      b    = (k >= NUP) ? hbits[k-NUP] : 1'b0;
      xfer = (ms == 2);
      drv  = xfer ? prev : b;
      if (xfer) prev = b;
      dr_hist[k] = drv;
      case (ms)
        0: if (b) begin ms = 1; mc = 0; ml = '0; end
        1: begin
          ml = {ml[30:0], b}; mc++;
          if (mc == 32) begin ms = (ml == 0) ? 3 : 2; mrem = int'(ml); prev = 1'b0; end
        end
        2: begin mrem--; if (mrem == 0) ms = 3; end
        default: ;
      endcase
      #1;
      chk(cs_n == !xfer, xfer ? "R3 cs_n in burst" : "R6 cs_n outside burst", cs_n, !xfer);
      if (k - NDN - 1 >= 0)
        chk(host_tdo == dr_hist[k-NDN-1], "R7 tdo readback", host_tdo, dr_hist[k-NDN-1]);
      else
        chk(host_tdo == 1'b0, "R7 tdo before data", host_tdo, 0);
    end
    @(negedge tck);
    shift = 1'b0; sel = 1'b0; host_tdi = 1'b0;
    #1 chk(cs_n == 1'b1, "R1 cs_n after shift exit", cs_n, 1);
    repeat (2) @(negedge tck);
    chk(nglitch == 0, "R9 no sclk with cs high", nglitch, 0);
  endtask

  task automatic check_rx(input string rq, input int n, input int len, input logic [63:0] data);
    chk(nclk == n, rq, nclk, n);
    chk(rx.size() == n, "R2 received bit count", rx.size(), n);
    for (int i = 0; i < n && i < rx.size(); i++)
      chk(rx[i] == data[len-1-i], "R4 mosi bit order", rx[i], data[len-1-i]);
  endtask

  task automatic frame(input int zeros, input int len, input logic [63:0] data, input string rq);
    build(zeros, len, data);
    run_scan(MAXB);
    check_rx(rq, len, len, data);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    chk(cs_n == 1'b1, "R10 reset cs_n", cs_n, 1);
    chk(d_tdo == 1'b0, "R10 reset tdo", d_tdo, 0);
    chk(sclk == 1'b0, "R10 reset sclk", sclk, 0);
    trst_n = 1'b1;
    repeat (2) @(negedge tck);

    frame(0, 8, 64'hA5, "R3 length 8 clocks");
    frame(5, 16, 64'h3C0F, "R2 leading zeros skipped");
    frame(2, 0, 64'h0, "R5 zero length no clocks");
    frame(0, 1, 64'h1, "R3 length 1");
    frame(1, 40, 64'hC3_5A0F_F0E1, "R3 length 40");

    build(1, 12, 64'hFFF);
    run_scan(NUP + 1 + 33 + 4);
    check_rx("R8 aborted burst clocks", 4, 12, 64'hFFF);
    frame(0, 8, 64'h96, "R8 clean frame after abort");

    build(0, 8, 64'hFF);
    nclk = 0; nglitch = 0;
    for (int k = 0; k < nh; k++) begin
      @(negedge tck);
      host_tdi = hbits[k]; sel = 1'b0; shift = 1'b1;
      @(posedge tck); #1;
      chk(cs_n == 1'b1, "R1 cs_n with instruction deselected", cs_n, 1);
    end
    @(negedge tck); shift = 1'b0;
    chk(nclk == 0, "R1 no sclk when deselected", nclk, 0);
    repeat (2) @(negedge tck);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      done = 1;
      nchecks++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end
endmodule